// File: doc/BRIEF.md
# Two-Stage Load/Store Processor Core

This block is a 32-bit processor core with two pipeline stages. In the first stage it fetches an instruction. In the second stage it decodes and executes that instruction. The core has one synchronous memory port, and both instruction fetch and data traffic use it. The memory returns read data one clock after it sees an address. A write takes effect on the clock edge where the write enable is high.

The register file has 32 entries. Register 31 is hard-wired to zero, and register 30 receives the return address when a trap is taken. The instruction set has the following classes:

- ALU operations in register-register form and in register-literal form.
- Word load, word store, and a PC-relative load.
- A register-indirect jump.
- Branch-if-zero and branch-if-nonzero.

Every control transfer is followed by one delay slot. A taken branch, a jump or a trap annuls the instruction in that slot. A not-taken branch lets it execute. Memory instructions hold the execute stage for a second cycle, because the port cannot fetch while it carries a data access. Unknown opcodes, including the multiply and divide codes, trap to address 4.

Top module: `duo_core`

## Requirements
- R1: While reset is high, the core drives fetch address 0 and holds the write enable low. The first fetch after reset is from address 0.
- R2: An instruction has an opcode in [31:26], rc in [25:21], ra in [20:16], rb in [15:11] and a signed literal in [15:0].
  - Opcode 10ffff computes rc = ra op rb. Opcode 11ffff computes rc = ra op sext(literal).
  - The function codes ffff are: add 0, sub 1, and 2, or 3, xor 4, equal 5, signed less-than 6, signed less-or-equal 7, shift-left 8, logical shift-right 9, arithmetic shift-right 10.
  - The shift amount is bits [4:0] of the second operand. A compare writes 1 when true and 0 when false.
- R3: Register 31 reads as zero, both as an operand and as store data. A write to register 31 has no effect.
- R4: The memory opcodes are:
  - 010000 is a load: rc = mem[ra + sext(lit)].
  - 010001 is a store: mem[ra + sext(lit)] = rc.
  - 010010 is a PC-relative load: rc = mem[PC+4 + 4*sext(lit)].
- R5: Every memory instruction takes two execute cycles.
  - Cycle 1 puts the data address on the port.
  - Cycle 2 receives the data and fetches the next sequential instruction.
  - A load result is usable by the very next instruction.
- R6: Each store raises the write enable for exactly one cycle, with the register value of rc on the write data.
- R7: Opcode 010110 branches when ra is zero. Opcode 010111 branches when ra is nonzero. Both write PC+4 into rc, and both target PC+4 + 4*sext(lit), forward or backward.
- R8: After a taken branch, a jump or a trap, the next instruction is annulled, even if it is an illegal word. After a not-taken branch, the next instruction executes.
- R9: Opcode 010100 writes PC+4 into rc. It then continues at the value of ra with bits [1:0] cleared.
- R10: Any other opcode traps, including ALU function codes 11 to 15. A trap writes PC+4 of the offending instruction into register 30 and continues at address 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for the fetch or data access |
| mem_rdata | input | 32 | Word read from the address presented one cycle earlier |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for the store |

## Verification
The hardest situations to reach from the ports combine a control transfer with the state of the shared port: the annulled delay slot, and a load whose result is consumed by the instruction right behind it. Small programs placed in the bench memory create both.

- A jump is followed by an all-zero word that would otherwise trap.
- A backward loop whose slot executes only on the final fall-through.
- A PC-relative load whose constant sits in an annulled slot.

The bench records the port address every cycle. It confirms that the data address falls between the load's own fetch and the fetch of its successor.

// File: rtl/duo_pkg.sv
package duo_pkg;

    localparam int XW = 32;
    localparam int OPW = 6;

    localparam logic [OPW-1:0] OP_LOAD  = 6'b010000;
    localparam logic [OPW-1:0] OP_STORE = 6'b010001;
    localparam logic [OPW-1:0] OP_LDREL = 6'b010010;
    localparam logic [OPW-1:0] OP_JUMP  = 6'b010100;
    localparam logic [OPW-1:0] OP_BZ    = 6'b010110;
    localparam logic [OPW-1:0] OP_BNZ   = 6'b010111;

    localparam logic [3:0] FN_LAST = 4'd10;

    typedef enum logic [1:0] {
        ST_BUBBLE,
        ST_RUN,
        ST_MEM2
    } phase_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_CEQ, ALU_CLT, ALU_CLE, ALU_SHL, ALU_SHR, ALU_SRA,
        ALU_PASSA
    } alu_e;

    typedef enum logic [1:0] {
        B_REG,
        B_LIT,
        B_LIT4
    } bsel_e;

    typedef struct packed {
        logic  legal;
        logic  rf_we;
        alu_e  fn;
        logic  a_pc;
        bsel_e bsel;
        logic  rb_is_rc;
        logic  is_mem;
        logic  is_st;
        logic  is_br;
        logic  br_on_nz;
        logic  is_jmp;
    } ctl_t;

    typedef struct packed {
        phase_e          ph;
        logic [XW-1:0]   pc;
        logic [XW-1:0]   ir;
    } core_state_t;

endpackage

// File: rtl/duo_regfile.sv
module duo_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

    logic [W-1:0] regs_q [NREG];

    // entry ZERO_IDX is never written, and reads of it are forced to zero
    always_ff @(posedge clk) begin
        if (we && wa != ZERO_IDX) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == ZERO_IDX) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == ZERO_IDX) ? '0 : regs_q[ra_b];

endmodule

// File: rtl/duo_decode.sv
module duo_decode
    import duo_pkg::*;
(
    input  logic [OPW-1:0] op,
    output ctl_t           ctl
);
    always_comb begin
        ctl    = '0;
        ctl.fn = ALU_ADD;
        case (op[5:4])
            2'b10, 2'b11: begin
                // function code doubles as ALU select; codes past FN_LAST trap
                ctl.legal = (op[3:0] <= FN_LAST);
                ctl.rf_we = ctl.legal;
                ctl.fn    = alu_e'(op[3:0]);
                ctl.bsel  = op[4] ? B_LIT : B_REG;
            end
            2'b01: begin
                case (op)
                    OP_LOAD: begin
                        ctl.legal  = 1'b1;
                        ctl.rf_we  = 1'b1;
                        ctl.is_mem = 1'b1;
                        ctl.bsel   = B_LIT;
                    end
                    OP_STORE: begin
                        ctl.legal    = 1'b1;
                        ctl.is_mem   = 1'b1;
                        ctl.is_st    = 1'b1;
                        ctl.bsel     = B_LIT;
                        ctl.rb_is_rc = 1'b1;
                    end
                    OP_LDREL: begin
                        ctl.legal  = 1'b1;
                        ctl.rf_we  = 1'b1;
                        ctl.is_mem = 1'b1;
                        ctl.a_pc   = 1'b1;
                        ctl.bsel   = B_LIT4;
                    end
                    OP_JUMP: begin
                        ctl.legal  = 1'b1;
                        ctl.rf_we  = 1'b1;
                        ctl.is_jmp = 1'b1;
                        ctl.fn     = ALU_PASSA;
                    end
                    OP_BZ, OP_BNZ: begin
                        ctl.legal    = 1'b1;
                        ctl.rf_we    = 1'b1;
                        ctl.is_br    = 1'b1;
                        ctl.br_on_nz = op[0];
                        ctl.a_pc     = 1'b1;
                        ctl.bsel     = B_LIT4;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/duo_alu.sv
module duo_alu
    import duo_pkg::*;
(
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  alu_e          fn,
    output logic [XW-1:0] y
);
    logic [4:0] sh;
    assign sh = b[4:0];

    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_CEQ: y = XW'(a == b);
            ALU_CLT: y = XW'($signed(a) < $signed(b));
            ALU_CLE: y = XW'($signed(a) <= $signed(b));
            ALU_SHL: y = a << sh;
            ALU_SHR: y = a >> sh;
            ALU_SRA: y = XW'($signed(a) >>> sh);
            default: y = a;
        endcase
    end

endmodule

// File: rtl/duo_core.sv
module duo_core
    import duo_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0004,
    parameter int          NREG     = 32
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_wdata,
    output logic        mem_we
);
    localparam int            AW     = $clog2(NREG);
    localparam logic [AW-1:0] XP_REG = AW'(NREG - 2);
    localparam logic [XW-1:0] STEP   = XW'(4);

    core_state_t   st_q, st_d;
    ctl_t          ctl;
    logic [XW-1:0] instr, sext, rd_a, rd_b, alu_a, alu_b, alu_y;
    logic [AW-1:0] rb_sel;
    logic          rf_we_c, trap_c, taken_c;
    logic [AW-1:0] rf_wa_c;
    logic [XW-1:0] rf_wd_c;

    // in the second memory cycle the port returns data, so the held word is decoded
    assign instr = (st_q.ph == ST_MEM2) ? st_q.ir : mem_rdata;
    assign sext  = {{(XW-16){instr[15]}}, instr[15:0]};

    duo_decode u_dec (
        .op  (instr[31:26]),
        .ctl (ctl)
    );

    assign rb_sel = ctl.rb_is_rc ? instr[25:21] : instr[15:11];

    duo_regfile #(.NREG(NREG), .W(XW)) u_rf (
        .clk  (clk),
        .ra_a (instr[20:16]),
        .ra_b (rb_sel),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we   (rf_we_c),
        .wa   (rf_wa_c),
        .wd   (rf_wd_c)
    );

    // st_q.pc already holds PC+4 of the executing instruction
    assign alu_a = ctl.a_pc ? st_q.pc : rd_a;
    always_comb begin
        case (ctl.bsel)
            B_LIT:   alu_b = sext;
            B_LIT4:  alu_b = {sext[XW-3:0], 2'b00};
            default: alu_b = rd_b;
        endcase
    end

    duo_alu u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .fn (ctl.fn),
        .y  (alu_y)
    );

    assign taken_c   = ctl.br_on_nz ? (rd_a != '0) : (rd_a == '0);
    assign mem_wdata = rd_b;

    always_comb begin
        st_d     = st_q;
        rf_we_c  = 1'b0;
        rf_wa_c  = instr[25:21];
        rf_wd_c  = alu_y;
        mem_addr = st_q.pc;
        mem_we   = 1'b0;
        trap_c   = 1'b0;
        case (st_q.ph)
            ST_RUN: begin
                if (!ctl.legal) begin
                    trap_c     = 1'b1;
                    rf_we_c    = 1'b1;
                    rf_wa_c    = XP_REG;
                    rf_wd_c    = st_q.pc;
                    st_d.pc    = TRAP_VEC;
                    st_d.ph    = ST_BUBBLE;
                end else if (ctl.is_mem) begin
                    // port carries the data access; next fetch waits one cycle
                    mem_addr   = alu_y;
                    mem_we     = ctl.is_st;
                    st_d.ir    = instr;
                    st_d.ph    = ST_MEM2;
                end else if (ctl.is_jmp) begin
                    rf_we_c    = ctl.rf_we;
                    rf_wd_c    = st_q.pc;
                    st_d.pc    = {alu_y[XW-1:2], 2'b00};
                    st_d.ph    = ST_BUBBLE;
                end else if (ctl.is_br) begin
                    rf_we_c    = ctl.rf_we;
                    rf_wd_c    = st_q.pc;
                    if (taken_c) begin
                        st_d.pc = alu_y;
                        st_d.ph = ST_BUBBLE;
                    end else begin
                        st_d.pc = st_q.pc + STEP;
                    end
                end else begin
                    rf_we_c    = ctl.rf_we;
                    st_d.pc    = st_q.pc + STEP;
                end
            end
            ST_MEM2: begin
                rf_we_c = ctl.rf_we;
                rf_wd_c = mem_rdata;
                st_d.pc = st_q.pc + STEP;
                st_d.ph = ST_RUN;
            end
            default: begin
                // word on the read port is the annulled slot or pre-reset noise
                st_d.pc = st_q.pc + STEP;
                st_d.ph = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= ST_BUBBLE;
            st_q.pc <= RESET_PC;
            st_q.ir <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/duo_core_chk.sv
module duo_core_chk
    import duo_pkg::*;
#(
    parameter logic [31:0] TRAP_VEC = 32'h0000_0004
) (
    input logic        clk,
    input logic        rst,
    input phase_e      ph,
    input logic [31:0] pc_q,
    input logic        mem_we,
    input logic        trap
);
    assert_mem2_run_R5: assert property (@(posedge clk) disable iff (rst)
        ph == ST_MEM2 |=> ph == ST_RUN);

    assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ph == ST_RUN && mem_we) |=> $stable(pc_q));

    assert_we_once_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!mem_we && ph == ST_MEM2));

    assert_trap_vec_R10: assert property (@(posedge clk) disable iff (rst)
        trap |=> (pc_q == TRAP_VEC && ph == ST_BUBBLE));

    assert_slot_single_R8: assert property (@(posedge clk) disable iff (rst)
        ph == ST_BUBBLE |=> ph == ST_RUN);

    assert_slot_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ph == ST_BUBBLE |-> (!mem_we && !trap));

endmodule

bind duo_core duo_core_chk #(.TRAP_VEC(TRAP_VEC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ph     (st_q.ph),
    .pc_q   (st_q.pc),
    .mem_we (mem_we),
    .trap   (trap_c)
);

// File: tb/test_duo_core.sv
module test_duo_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we;

    logic [31:0] ram [0:255];
    logic [31:0] trace [0:1023];
    int errs = 0, checks = 0, we_cnt = 0, tlen = 0, apc = 0;
    bit tracing = 1'b0;

    localparam logic [5:0] OP_LOAD = 6'b010000, OP_STORE = 6'b010001, OP_LDREL = 6'b010010;
    localparam logic [5:0] OP_JUMP = 6'b010100, OP_BZ = 6'b010110, OP_BNZ = 6'b010111;
    localparam logic [3:0] F_ADD = 0, F_SUB = 1, F_AND = 2, F_OR = 3, F_XOR = 4, F_CEQ = 5;
    localparam logic [3:0] F_CLT = 6, F_CLE = 7, F_SHL = 8, F_SHR = 9, F_SRA = 10, F_MUL = 11;

    always #2.5 clk = ~clk;

    duo_core i_duo_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    always @(posedge clk) begin
        mem_rdata <= ram[mem_addr[9:2]];
        if (mem_we) ram[mem_addr[9:2]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (tracing) begin
            if (tlen < 1024) trace[tlen] = mem_addr;
            tlen++;
            if (mem_we) we_cnt++;
        end
    end

    function automatic logic [5:0] rr(logic [3:0] f); return {2'b10, f}; endfunction
    function automatic logic [5:0] ri(logic [3:0] f); return {2'b11, f}; endfunction
    function automatic logic [31:0] ins_r(logic [5:0] op, int rc, int ra, int rb);
        return {op, rc[4:0], ra[4:0], rb[4:0], 11'd0};
    endfunction
    function automatic logic [31:0] ins_l(logic [5:0] op, int rc, int ra, int lit);
        return {op, rc[4:0], ra[4:0], lit[15:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(logic [31:0] w);
        ram[apc >> 2] = w;
        apc += 4;
    endtask

    // entry branch to 0x40; trap handler at 4 saves r30 and r1, then spins
    task automatic setup();
        for (int i = 0; i < 256; i++) ram[i] = '0;
        ram[0] = ins_l(OP_BZ, 31, 31, 15);
        ram[1] = ins_l(OP_STORE, 30, 31, 'h3F0);
        ram[2] = ins_l(OP_STORE, 1, 31, 'h3F4);
        ram[3] = ins_l(OP_BZ, 31, 31, -1);
        apc = 'h40;
    endtask

    task automatic halt();
        put(ins_l(OP_BZ, 31, 31, -1));
    endtask

    task automatic run(int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        we_cnt = 0;
        tlen = 0;
        tracing = 1'b1;
        repeat (n) @(negedge clk);
        tracing = 1'b0;
    endtask

    function automatic logic [31:0] rd(int addr);
        return ram[addr >> 2];
    endfunction

    task automatic t_reset();
        setup();
        halt();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset fetch address", mem_addr, 32'h0);
        chk("R1 reset write enable", {31'd0, mem_we}, 32'h0);
        rst = 1'b0;
        #1;
        chk("R1 first fetch address", mem_addr, 32'h0);
    endtask

    task automatic t_alu();
        logic [31:0] e [17] = '{32'h7, 32'hFFFFFFFD, 32'h4, 32'hA, 32'h5, 32'hFFFFFFFF,
            32'hFFFFFFFA, 32'h1, 32'h0, 32'h1, 32'h0, 32'h70, 32'h0FFFFFFF,
            32'hFFFFFFFE, 32'hFFFFFFFF, 32'h1, 32'hFFFFFFF8};
        setup();
        put(ins_l(ri(F_ADD), 1, 31, 7));
        put(ins_l(ri(F_ADD), 2, 31, -3));
        put(ins_r(rr(F_ADD), 3, 1, 2));
        put(ins_r(rr(F_SUB), 4, 1, 2));
        put(ins_r(rr(F_AND), 5, 1, 2));
        put(ins_r(rr(F_OR), 6, 1, 2));
        put(ins_r(rr(F_XOR), 7, 1, 2));
        put(ins_r(rr(F_CLT), 8, 2, 1));
        put(ins_r(rr(F_CLT), 9, 1, 2));
        put(ins_r(rr(F_CLE), 10, 1, 1));
        put(ins_r(rr(F_CEQ), 11, 1, 2));
        put(ins_l(ri(F_SHL), 12, 1, 4));
        put(ins_l(ri(F_SHR), 13, 2, 4));
        put(ins_l(ri(F_SRA), 14, 2, 1));
        put(ins_r(rr(F_SRA), 15, 2, 1));
        put(ins_l(ri(F_CEQ), 16, 1, 7));
        put(ins_l(ri(F_XOR), 17, 1, -1));
        for (int k = 1; k <= 17; k++) put(ins_l(OP_STORE, k, 31, 'h200 + 4 * (k - 1)));
        halt();
        run(200);
        for (int k = 0; k < 17; k++) chk($sformatf("R2 alu result r%0d", k + 1), rd('h200 + 4 * k), e[k]);
        chk("R10 no trap in alu program", rd('h3F0), 32'h0);
    endtask

    task automatic t_mem();
        int idx = -1;
        setup();
        ram['h300 >> 2] = 32'h12345678;
        put(ins_l(OP_LOAD, 1, 31, 'h300));
        put(ins_l(ri(F_ADD), 2, 1, 1));
        put(ins_l(OP_STORE, 2, 31, 'h204));
        put(ins_l(OP_LDREL, 3, 31, 1));
        put(ins_l(OP_BZ, 31, 31, 1));
        put(32'hCAFEF00D);
        put(ins_l(OP_STORE, 3, 31, 'h208));
        put(ins_l(ri(F_ADD), 4, 31, 'h310));
        put(ins_l(OP_STORE, 1, 4, -8));
        put(ins_l(ri(F_ADD), 31, 31, 9));
        put(ins_l(OP_STORE, 31, 31, 'h20C));
        put(ins_r(rr(F_ADD), 5, 31, 1));
        put(ins_l(OP_STORE, 5, 31, 'h210));
        halt();
        run(120);
        chk("R5 load result used at once", rd('h204), 32'h12345679);
        chk("R4 pc-relative load", rd('h208), 32'hCAFEF00D);
        chk("R4 store with negative literal", rd('h308), 32'h12345678);
        chk("R3 r31 ignores write", rd('h20C), 32'h0);
        chk("R3 r31 operand is zero", rd('h210), 32'h12345678);
        chk("R6 write strobe count", 32'(we_cnt), 32'd5);
        for (int i = 0; i < tlen && i < 1024; i++) if (idx < 0 && trace[i] == 32'h300) idx = i;
        chk("R5 data address on port", 32'(idx > 0), 32'h1);
        if (idx > 0) begin
            chk("R5 load fetched before access", trace[idx - 1], 32'h40);
            chk("R5 next fetch after access", trace[idx + 1], 32'h44);
        end
    endtask

    task automatic t_branch();
        setup();
        put(ins_l(ri(F_ADD), 1, 31, 3));
        put(ins_l(ri(F_ADD), 5, 31, 0));
        put(ins_l(ri(F_ADD), 8, 31, 0));
        put(ins_l(ri(F_ADD), 12, 31, 0));
        put(ins_l(ri(F_ADD), 13, 31, 0));
        put(ins_l(OP_BZ, 2, 1, 5));          // 0x54 not taken
        put(ins_l(ri(F_ADD), 3, 31, 1));     // 0x58 executes
        put(ins_l(OP_BNZ, 4, 1, 2));         // 0x5C taken to 0x68
        put(ins_l(ri(F_ADD), 5, 31, 1));     // 0x60 annulled
        put(ins_l(ri(F_ADD), 5, 31, 2));     // 0x64 skipped
        put(ins_l(ri(F_ADD), 6, 31, 'h83));  // 0x68
        put(ins_l(OP_JUMP, 7, 6, 0));        // 0x6C to 0x80
        put(32'h0);                          // 0x70 illegal word in annulled slot
        put(ins_l(ri(F_ADD), 8, 31, 2));
        put(ins_l(ri(F_ADD), 8, 31, 2));
        put(ins_l(ri(F_ADD), 8, 31, 2));
        put(ins_l(ri(F_ADD), 10, 31, 3));    // 0x80
        put(ins_l(ri(F_ADD), 12, 12, 1));    // 0x84 loop head
        put(ins_l(ri(F_SUB), 10, 10, 1));
        put(ins_l(OP_BNZ, 31, 10, -3));      // 0x8C back to 0x84
        put(ins_l(ri(F_ADD), 13, 13, 1));    // 0x90 slot
        put(ins_l(OP_STORE, 2, 31, 'h200));
        put(ins_l(OP_STORE, 3, 31, 'h204));
        put(ins_l(OP_STORE, 4, 31, 'h208));
        put(ins_l(OP_STORE, 5, 31, 'h20C));
        put(ins_l(OP_STORE, 7, 31, 'h210));
        put(ins_l(OP_STORE, 8, 31, 'h214));
        put(ins_l(OP_STORE, 12, 31, 'h218));
        put(ins_l(OP_STORE, 13, 31, 'h21C));
        halt();
        run(200);
        chk("R7 link of not-taken branch", rd('h200), 32'h58);
        chk("R8 not-taken slot executes", rd('h204), 32'h1);
        chk("R7 link of taken branch", rd('h208), 32'h60);
        chk("R8 taken branch slot annulled", rd('h20C), 32'h0);
        chk("R9 jump link", rd('h210), 32'h70);
        chk("R9 jump target low bits cleared", rd('h214), 32'h0);
        chk("R7 backward branch iterations", rd('h218), 32'h3);
        chk("R8 loop slot only on fall-through", rd('h21C), 32'h1);
        chk("R8 illegal word in annulled slot", rd('h3F0), 32'h0);
    endtask

    task automatic t_trap(logic [31:0] bad, string tag);
        setup();
        put(ins_l(ri(F_ADD), 1, 31, 1));
        put(bad);
        put(ins_l(ri(F_ADD), 1, 31, 5));
        halt();
        run(60);
        chk({"R10 return address, ", tag}, rd('h3F0), 32'h48);
        chk({"R10 slot after trap annulled, ", tag}, rd('h3F4), 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_mem();
        t_branch();
        t_trap(32'h0, "class 00");
        t_trap(ins_r(rr(F_MUL), 1, 1, 1), "multiply code");
        t_trap({6'b011111, 26'd0}, "unused memory-class code");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule